// File: doc/BRIEF.md
# Strobe-Driven Pin Control Word

This block holds the output level and the driver enable for up to eight general-purpose pins behind one 32-bit register word. Software never writes a pin's state directly. Instead, each pin owns four one-shot strobe bits: one raises the output level, one lowers it, one turns the driver on and one turns it off. A single write can therefore change any pin without a read-modify-write, and writes to different pins never disturb each other.

The lower half-word carries the level strobes and the upper half-word carries the driver strobes, with two bits per pin. A read returns a status view rather than the last value written: the driver state, the level latch, and the synchronized pin input while the pin is not driven. A full chip places two copies of the block. One has eight pins. The other is built with `PIN_COUNT` set to 4, and its four upper slots read as zero and ignore writes. The register port is a plain write strobe plus a continuously valid read word, so it has no back-pressure.

Top module: `pinpair_ctl`

## Requirements
- R1: While reset is asserted and just after it is released, `pad_oe` and `pad_out` are all 0 and `reg_rdata` is 0, whatever `pad_in` is.
- R2: For local pin n, a write with bit 2n+1 set and bit 2n clear makes `pad_out[n]` 1 from the cycle after the write edge. A write with bit 2n set and bit 2n+1 clear makes it 0.
- R3: For local pin n, a write with bit 16+2n set and bit 17+2n clear makes `pad_oe[n]` 1 from the cycle after the write edge. A write with bit 17+2n set and bit 16+2n clear makes it 0.
- R4: A write that sets both bits of a strobe pair (2n and 2n+1, or 16+2n and 17+2n) leaves the affected latch unchanged.
- R5: Zero bits in a written word, and cycles without `reg_wr`, change no latch.
- R6: `reg_rdata` bit 2n equals `pad_out[n]`, bit 16+2n equals `pad_oe[n]`, and bit 17+2n reads 0.
- R7: `reg_rdata` bit 2n+1 equals `pad_in[n]` delayed by two clock edges through a synchronizer, forced to 0 while `pad_oe[n]` is 1.
- R8: For slots n >= `PIN_COUNT`, all four read bits are 0 and writes to them have no visible effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Strobe bits for the write |
| reg_rdata | output | 32 | Status view word |
| pad_out | output | PIN_COUNT | Output level per pin |
| pad_oe | output | PIN_COUNT | Output driver enable per pin |
| pad_in | input | PIN_COUNT | Raw pin input level |

## Verification
The bench targets the following corner cases:
- **Both strobes of a pair set at once.** A design that let one strobe win would move the latch instead of holding it.
- **Words of all set strobes or all clear strobes.** These catch a pair swapped between the level half and the driver half.
- **Input latency.** The bench checks the input read bit one edge and then two edges after a change to `pad_in`. A synchronizer with the wrong depth shows up as the new value appearing too early or too late.
- **Input bit while driven.** A design that did not mask the input bit with the driver enable would report the pin high while it is driving.

A four-pin copy of the block receives the same random writes as the full copy. Any leakage into the unimplemented slots shows up as nonzero upper read bits.

// File: rtl/pinpair_pkg.sv
package pinpair_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int SLOT_MAX = HALF_W / 2;

  typedef struct packed {
    logic lo;   // drive level low
    logic hi;   // drive level high
    logic on;   // driver enable
    logic off;  // driver disable
  } strobe_t;

  function automatic strobe_t pick_strobes(input logic [WORD_W-1:0] w, input int n);
    strobe_t s;
    s.lo  = w[2*n];
    s.hi  = w[2*n+1];
    s.on  = w[HALF_W+2*n];
    s.off = w[HALF_W+2*n+1];
    return s;
  endfunction

  // Pair resolution: a single raise or lower strobe acts; both or none hold.
  function automatic logic resolve_pair(input logic cur, input logic up, input logic down);
    logic r;
    case ({up, down})
      2'b10:   r = 1'b1;
      2'b01:   r = 1'b0;
      default: r = cur;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pinpair_sync.sv
module pinpair_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[LAST];
endmodule

// File: rtl/pinpair_slot.sv
module pinpair_slot
  import pinpair_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  strobe_t stb,
  output logic    lvl,
  output logic    drv
);
  logic lvl_nx, drv_nx;

  always_comb begin
    lvl_nx = lvl;
    drv_nx = drv;
    if (wr) begin
      lvl_nx = resolve_pair(lvl, stb.hi, stb.lo);
      drv_nx = resolve_pair(drv, stb.on, stb.off);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      drv <= 1'b0;
    end else begin
      lvl <= lvl_nx;
      drv <= drv_nx;
    end
  end
endmodule

// File: rtl/pinpair_view.sv
module pinpair_view
  import pinpair_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic [PIN_COUNT-1:0] lvl,
  input  logic [PIN_COUNT-1:0] drv,
  input  logic [PIN_COUNT-1:0] in_s,
  output logic [WORD_W-1:0]    view
);
  for (genvar n = 0; n < SLOT_MAX; n++) begin : g_view
    if (n < PIN_COUNT) begin : g_live
      assign view[2*n]          = lvl[n];
      assign view[2*n+1]        = in_s[n] & ~drv[n];
      assign view[HALF_W+2*n]   = drv[n];
      assign view[HALF_W+2*n+1] = 1'b0;
    end else begin : g_dead
      assign view[2*n+1:2*n]               = 2'b00;
      assign view[HALF_W+2*n+1:HALF_W+2*n] = 2'b00;
    end
  end
endmodule

// File: rtl/pinpair_ctl.sv
module pinpair_ctl
  import pinpair_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic [PIN_COUNT-1:0] pad_out,
  output logic [PIN_COUNT-1:0] pad_oe,
  input  logic [PIN_COUNT-1:0] pad_in
);
  logic [PIN_COUNT-1:0] in_s;

  pinpair_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_s)
  );

  for (genvar n = 0; n < SLOT_MAX; n++) begin : g_slot
    if (n < PIN_COUNT) begin : g_live
      pinpair_slot u_slot (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr),
        .stb(pick_strobes(reg_wdata, n)),
        .lvl(pad_out[n]), .drv(pad_oe[n])
      );
    end else begin : g_dead
      logic unused_stb;
      assign unused_stb = ^{reg_wdata[2*n+1:2*n], reg_wdata[HALF_W+2*n+1:HALF_W+2*n]};
    end
  end

  pinpair_view #(.PIN_COUNT(PIN_COUNT)) u_view (
    .lvl(pad_out), .drv(pad_oe), .in_s(in_s), .view(reg_rdata)
  );
endmodule

// File: rtl/pinpair_ctl_chk.sv
module pinpair_ctl_chk #(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic [PIN_COUNT-1:0] pad_out,
  input logic [PIN_COUNT-1:0] pad_oe,
  input logic [PIN_COUNT-1:0] pad_in
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(pad_out) && $stable(pad_oe)));

  for (genvar n = 0; n < 8; n++) begin : g_pin
    if (n < PIN_COUNT) begin : g_live
      p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[2*n+1] && !reg_wdata[2*n]) |=> pad_out[n]);
      p_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[2*n] && !reg_wdata[2*n+1]) |=> !pad_out[n]);
      p_drv_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[16+2*n] && !reg_wdata[17+2*n]) |=> pad_oe[n]);
      p_pair_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[2*n] && reg_wdata[2*n+1]) |=> $stable(pad_out[n]));
      p_view_drv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[16+2*n] == pad_oe[n]) && (reg_rdata[2*n] == pad_out[n]));
      p_in_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[n] |-> !reg_rdata[2*n+1]);
    end else begin : g_dead
      p_dead_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[2*n+1:2*n] == 2'b00) && (reg_rdata[17+2*n:16+2*n] == 2'b00));
    end
  end
endmodule

bind pinpair_ctl pinpair_ctl_chk #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/pinpair_ctl_tb.sv
`timescale 1ns/1ps
module pinpair_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  pad_in = '0;
  logic [31:0] rd8, rd4;
  logic [7:0]  out8, oe8;
  logic [3:0]  out4, oe4;
  logic [7:0]  m_out8 = '0, m_oe8 = '0, m_out4 = '0, m_oe4 = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pinpair_ctl #(.PIN_COUNT(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd8), .pad_out(out8), .pad_oe(oe8), .pad_in(pad_in)
  );
  pinpair_ctl #(.PIN_COUNT(4)) u_dut_half (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rd4), .pad_out(out4), .pad_oe(oe4), .pad_in(pad_in[3:0])
  );

  function automatic logic [7:0] upd(input logic [7:0] cur, input logic [31:0] w,
                                     input int base, input int np);
    logic [7:0] r = cur;
    for (int n = 0; n < np; n++) begin
      if (w[base+2*n+1] && !w[base+2*n])      r[n] = (base == 0) ? 1'b1 : 1'b0;
      else if (w[base+2*n] && !w[base+2*n+1]) r[n] = (base == 0) ? 1'b0 : 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] lv, input logic [7:0] dv,
                                         input logic [7:0] pin, input int np);
    logic [31:0] r = '0;
    for (int n = 0; n < np; n++) begin
      r[2*n]    = lv[n];
      r[2*n+1]  = pin[n] & ~dv[n];
      r[16+2*n] = dv[n];
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic verify(input string tag);
    chk({tag, " out8"}, {24'h0, out8}, {24'h0, m_out8});
    chk({tag, " oe8"},  {24'h0, oe8},  {24'h0, m_oe8});
    chk({tag, " rd8"},  rd8, exp_rd(m_out8, m_oe8, pad_in, 8));
    chk({tag, " out4"}, {28'h0, out4}, {28'h0, m_out4[3:0]});
    chk({tag, " oe4"},  {28'h0, oe4},  {28'h0, m_oe4[3:0]});
    chk({tag, " rd4 R8"}, rd4, exp_rd(m_out4, m_oe4, pad_in, 4));
  endtask

  // One write (or idle) cycle, then two settle edges for the synchronizer.
  task automatic step(input bit w, input logic [31:0] d, input logic [7:0] pin,
                      input string tag);
    @(negedge clk);
    reg_wr = w; reg_wdata = d; pad_in = pin;
    if (w) begin
      m_out8 = upd(m_out8, d, 0, 8);  m_oe8 = upd(m_oe8, d, 16, 8);
      m_out4 = upd(m_out4, d, 0, 4);  m_oe4 = upd(m_oe4, d, 16, 4);
    end
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
    verify(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state regardless of pad_in
    chk("R1 rd8", rd8, 32'h0);
    chk("R1 oe8", {24'h0, oe8}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out8", {24'h0, out8}, 32'h0);
    chk("R1 rd4", rd4, 32'h0);

    step(1, 32'h0000_0080, 8'h00, "R2 raise pin3");
    step(1, 32'h0000_0040, 8'h00, "R2 lower pin3");
    step(1, 32'h0001_0000, 8'h00, "R3 enable pin0");
    step(1, 32'h0002_0000, 8'h00, "R3 disable pin0");
    step(1, 32'h0000_0002, 8'h00, "R2 raise pin0");
    step(1, 32'h0000_0003, 8'h00, "R4 level pair both");
    step(1, 32'h0004_0000, 8'h00, "R3 enable pin1");
    step(1, 32'h000C_0000, 8'h00, "R4 driver pair both");
    step(1, 32'h0000_0000, 8'h00, "R5 zero word");
    step(0, 32'hFFFF_FFFF, 8'h00, "R5 no write");
    step(1, 32'hAAAA_AAAA, 8'h00, "R6 all raise all off");
    step(1, 32'h5555_5555, 8'h00, "R6 all lower all on");
    step(1, 32'hFFFF_FFFF, 8'hFF, "R4 every pair both");
    // R7: input masked while driven
    step(0, 32'h0, 8'hFF, "R7 driven masks input");
    step(1, 32'hAAAA_0000, 8'hFF, "R7 undriven shows input");

    // R7: latency through two-stage synchronizer
    @(negedge clk);
    pad_in = 8'h00;
    @(negedge clk);
    chk("R7 one edge old", rd8 & 32'h0000_AAAA, exp_rd(m_out8, m_oe8, 8'hFF, 8) & 32'h0000_AAAA);
    @(negedge clk);
    chk("R7 two edges new", rd8 & 32'h0000_AAAA, 32'h0);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [7:0]  p;
      w = $urandom();
      p = 8'($urandom());
      step(1, w, p, "R2 R3 R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule